// File: doc/BRIEF.md
# APB Multi-Channel Countdown Timer

This block is an APB slave with eight independent down-counters. Each counter has four registers: a control word, a reload value, a compare value that is only stored, and a read-only view of the remaining count. All counters advance on a shared one-cycle `tick` strobe that comes from the APB clock domain. Each counter has its own interrupt line and its own bit in a common status word.

Software loads a counter by writing its reload register. A single control write can then copy the reload value into the counter and start it. When the counter runs out, it reports the event in the status word and on its interrupt line. The line either stays high until software clears the status bit, or gives a one-cycle pulse; each counter picks this for itself. After the event the counter either reloads and keeps running, or stops and drops its start bit. Status bits are cleared by writing ones to them.

Top module: `apb_cd_timer`

## Requirements
- R1: After reset, every control, reload and compare register reads 0, the status word reads 0, every `irq` bit is low and every current-count view reads 0.
- R2: Timer n (1 to 8) owns the 16-byte bank at byte address n*16, with these word offsets:
  - +0x0: control.
  - +0x4: reload.
  - +0x8: compare. It reads back as written and has no effect on counting.
  - +0xC: current count.
  
  The control word reads back its bits 0, 1, 2, 4, 5 and 6 as written; every other control bit reads 0.
- R3: Accesses to undefined locations read 0, and writes to them change nothing. Undefined locations are:
  - offsets 0x4 to 0xC of bank 0;
  - the bank at 0x90;
  - addresses above the last timer;
  - any address with bits [1:0] not zero.
  
  Writes to a current-count register are ignored.
- R4: A control write with bit 2 (update) set copies the reload register into the counter. If bit 1 (start) is also set, counting starts from that value. The current-count register returns the counter while start is set, and 0 otherwise.
- R5: A started timer decrements once for each clock edge at which `tick` is high. It expires on the tick that finds the counter at 1, so a load of N expires on the N-th tick. A started counter holding 0 does not move.
- R6: On expiry with bit 4 (auto-reload) clear, the start bit clears itself, the count reads 0 and the timer stays stopped.
- R7: On expiry with auto-reload set, the counter reloads from the reload register and keeps running, so a load of N expires every N ticks.
- R8: On expiry with bit 5 (interrupt enable) set, status bit n-1 sets at that clock edge. With bit 5 clear, neither status nor `irq` changes.
- R9: With bit 6 clear (level mode), `irq[n-1]` goes high at expiry and stays high until status bit n-1 is cleared.
- R10: With bit 6 set (pulse mode), `irq[n-1]` is high for exactly one cycle after each expiry.
- R11: Status lives at address 0x00; bit k belongs to timer k+1. A write there clears each status bit written as 1 and leaves bits written as 0 unchanged. An expiry in the same cycle wins over the clear.
- R12: `pready` is always 1 and `pslverr` is always 0.
- R13: A control write with start clear freezes the counter and the count reads 0. A later write with start set and update clear resumes from the frozen value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | APB clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Shared count strobe, one cycle per count |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| irq | output | NUM_TMR | Per-timer interrupt lines |

## Verification
The assertions assume that `tick` and the APB inputs are known at every clock edge once reset is released. They also assume that a write is counted only on a cycle where `psel` and `penable` are both high.

The stimulus keeps to full two-phase APB transfers and drives all inputs half a cycle away from the sampling edge. It holds `tick` low during every register access, so that each expected count follows only from the number of tick bursts issued. Before a status-clear test, it stops any auto-reloading timer, so that no expiry can land on the same edge as the clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned CTRL_W = 7;

    // Word slot inside one timer bank, taken from address bits [3:2]
    typedef enum logic [1:0] {
        SLOT_CTRL   = 2'd0,
        SLOT_RELOAD = 2'd1,
        SLOT_CMP    = 2'd2,
        SLOT_COUNT  = 2'd3
    } slot_e;

    // Control word, LSB first: ext, run, load, rsv, auto_rl, ien, pulse
    typedef struct packed {
        logic pulse;    // 1: one-cycle interrupt, 0: held interrupt
        logic ien;      // interrupt enable
        logic auto_rl;  // reload on expiry
        logic rsv;      // reserved, always stored as 0
        logic load;     // copy reload into counter on write
        logic run;      // counting enabled
        logic ext;      // clock select, stored only
    } tmr_ctrl_t;

    function automatic tmr_ctrl_t ctrl_from_bits(input logic [CTRL_W-1:0] w);
        tmr_ctrl_t c;
        c     = tmr_ctrl_t'(w);
        c.rsv = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
    import tmr_pkg::*;
#(
    parameter int unsigned AW      = 12,
    parameter int unsigned NUM_TMR = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [AW-1:0]    paddr,
    output logic             status_hit,
    output logic             tmr_hit,
    output logic [IDX_W-1:0] tmr_idx,
    output slot_e            slot
);
    localparam int unsigned BANK_W = AW - 4;

    logic [BANK_W-1:0] bank;
    logic [BANK_W-1:0] bank_m1;
    logic              aligned;

    always_comb begin
        bank       = paddr[AW-1:4];
        bank_m1    = bank - BANK_W'(1);
        aligned    = (paddr[1:0] == 2'b00);
        slot       = slot_e'(paddr[3:2]);
        status_hit = aligned && (bank == '0) && (paddr[3:2] == 2'b00);
        tmr_hit    = aligned && (bank != '0) && (bank <= BANK_W'(NUM_TMR));
        tmr_idx    = bank_m1[IDX_W-1:0];
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_ctrl,
    input  logic             wr_reload,
    input  logic             wr_cmp,
    input  logic [BUS_W-1:0] wdata,
    input  logic             clr_irq,
    output tmr_ctrl_t        ctrl_q,
    output logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic [CNT_W-1:0] count_rd,
    output logic             expire,
    output logic             irq
);
    logic [CNT_W-1:0] cnt_q;
    logic             step;
    logic             lvl_q;
    logic             pulse_q;

    // A control write in the same cycle takes precedence over the tick
    always_comb begin
        step     = tick && ctrl_q.run && !wr_ctrl && (cnt_q != '0);
        expire   = step && (cnt_q == CNT_W'(1));
        count_rd = ctrl_q.run ? cnt_q : '0;
        irq      = lvl_q || pulse_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            cmp_q    <= '0;
            cnt_q    <= '0;
            lvl_q    <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (clr_irq)   lvl_q    <= 1'b0;
            if (wr_reload) reload_q <= wdata[CNT_W-1:0];
            if (wr_cmp)    cmp_q    <= wdata[CNT_W-1:0];
            if (wr_ctrl) begin
                ctrl_q <= ctrl_from_bits(wdata[CTRL_W-1:0]);
                if (wdata[2]) cnt_q <= reload_q;
            end else if (expire) begin
                if (ctrl_q.auto_rl) begin
                    cnt_q <= reload_q;
                end else begin
                    cnt_q      <= '0;
                    ctrl_q.run <= 1'b0;
                end
                if (ctrl_q.ien) begin
                    if (ctrl_q.pulse) pulse_q <= 1'b1;
                    else              lvl_q   <= 1'b1;
                end
            end else if (step) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/apb_cd_timer.sv
module apb_cd_timer
    import tmr_pkg::*;
#(
    parameter int unsigned AW      = 12,
    parameter int unsigned NUM_TMR = 8,
    parameter int unsigned CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [AW-1:0]      paddr,
    input  logic [BUS_W-1:0]   pwdata,
    output logic [BUS_W-1:0]   prdata,
    output logic               pready,
    output logic               pslverr,
    output logic [NUM_TMR-1:0] irq
);
    localparam int unsigned IDX_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

    logic             status_hit;
    logic             tmr_hit;
    logic [IDX_W-1:0] tmr_idx;
    slot_e            slot;
    logic             wr_en;
    logic             status_wr;

    tmr_ctrl_t        ctrl_a   [NUM_TMR];
    logic [CNT_W-1:0] reload_a [NUM_TMR];
    logic [CNT_W-1:0] cmp_a    [NUM_TMR];
    logic [CNT_W-1:0] cnt_a    [NUM_TMR];

    logic [NUM_TMR-1:0] exp_vec;
    logic [NUM_TMR-1:0] ien_vec;
    logic [NUM_TMR-1:0] auto_vec;
    logic [NUM_TMR-1:0] run_vec;
    logic [NUM_TMR-1:0] set_mask;
    logic [NUM_TMR-1:0] clr_mask;
    logic [NUM_TMR-1:0] status_q;

    tmr_regdec #(.AW(AW), .NUM_TMR(NUM_TMR), .IDX_W(IDX_W)) dec_i (
        .paddr      (paddr),
        .status_hit (status_hit),
        .tmr_hit    (tmr_hit),
        .tmr_idx    (tmr_idx),
        .slot       (slot)
    );

    assign wr_en     = psel && penable && pwrite;
    assign status_wr = wr_en && status_hit;
    assign clr_mask  = status_wr ? pwdata[NUM_TMR-1:0] : '0;
    assign pready    = 1'b1;
    assign pslverr   = 1'b0;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        logic sel;
        assign sel = wr_en && tmr_hit && (tmr_idx == IDX_W'(i));

        tmr_chan #(.CNT_W(CNT_W)) chan_i (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .wr_ctrl   (sel && (slot == SLOT_CTRL)),
            .wr_reload (sel && (slot == SLOT_RELOAD)),
            .wr_cmp    (sel && (slot == SLOT_CMP)),
            .wdata     (pwdata),
            .clr_irq   (clr_mask[i]),
            .ctrl_q    (ctrl_a[i]),
            .reload_q  (reload_a[i]),
            .cmp_q     (cmp_a[i]),
            .count_rd  (cnt_a[i]),
            .expire    (exp_vec[i]),
            .irq       (irq[i])
        );

        assign ien_vec[i]  = ctrl_a[i].ien;
        assign auto_vec[i] = ctrl_a[i].auto_rl;
        assign run_vec[i]  = ctrl_a[i].run;
    end

    assign set_mask = exp_vec & ien_vec;

    // Set wins over a concurrent write-one-to-clear
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_mask) | set_mask;
    end

    always_comb begin
        prdata = '0;
        if (status_hit) begin
            prdata[NUM_TMR-1:0] = status_q;
        end else if (tmr_hit) begin
            unique case (slot)
                SLOT_CTRL:   prdata[CTRL_W-1:0] = ctrl_a[tmr_idx];
                SLOT_RELOAD: prdata[CNT_W-1:0]  = reload_a[tmr_idx];
                SLOT_CMP:    prdata[CNT_W-1:0]  = cmp_a[tmr_idx];
                SLOT_COUNT:  prdata[CNT_W-1:0]  = cnt_a[tmr_idx];
                default:     prdata             = '0;
            endcase
        end
    end

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int unsigned NUM_TMR = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               status_wr,
    input logic [31:0]        pwdata,
    input logic               pready,
    input logic               pslverr,
    input logic [NUM_TMR-1:0] irq,
    input logic [NUM_TMR-1:0] status_q,
    input logic [NUM_TMR-1:0] exp_vec,
    input logic [NUM_TMR-1:0] ien_vec,
    input logic [NUM_TMR-1:0] auto_vec,
    input logic [NUM_TMR-1:0] run_vec
);
    assert_apb_resp_R12: assert property (@(posedge clk) disable iff (rst)
        pready && !pslverr);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        assert_status_set_R8: assert property (@(posedge clk) disable iff (rst)
            (exp_vec[i] && ien_vec[i]) |=> status_q[i]);

        assert_status_clr_R11: assert property (@(posedge clk) disable iff (rst)
            (status_wr && pwdata[i] && !(exp_vec[i] && ien_vec[i])) |=> !status_q[i]);

        assert_status_keep_R11: assert property (@(posedge clk) disable iff (rst)
            (!status_wr && !exp_vec[i]) |=> $stable(status_q[i]));

        assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (rst)
            (exp_vec[i] && !auto_vec[i]) |=> !run_vec[i]);

        assert_irq_drop_R9: assert property (@(posedge clk) disable iff (rst)
            $fell(status_q[i]) |-> !irq[i]);
    end

endmodule

bind apb_cd_timer tmr_chk #(.NUM_TMR(NUM_TMR)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .status_wr (status_wr),
    .pwdata    (pwdata),
    .pready    (pready),
    .pslverr   (pslverr),
    .irq       (irq),
    .status_q  (status_q),
    .exp_vec   (exp_vec),
    .ien_vec   (ien_vec),
    .auto_vec  (auto_vec),
    .run_vec   (run_vec)
);

// File: tb/apb_cd_timer_tb_top.sv
module apb_cd_timer_tb_top;

    localparam int AW = 12;
    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready;
    logic          pslverr;
    logic [NT-1:0] irq;

    int n_chk = 0;
    int n_bad = 0;
    int pulse_hits = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    apb_cd_timer #(.AW(AW), .NUM_TMR(NT), .CNT_W(32)) dut_i (
        .clk(clk), .rst(rst), .tick(tick), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #2 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        logic [31:0] v;
        apb_rd(a, v);
        check(req, v, exp);
    endtask

    // n clock edges with tick high; counts irq[1] samples seen high
    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (irq[1]) pulse_hits++;
        end
        tick = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 irq", 32'(irq), 32'h0);
        check("R12 pready", 32'(pready), 32'h1);
        check("R12 pslverr", 32'(pslverr), 32'h0);
        rd_check("R1 status", 12'h000, 32'h0);
        rd_check("R1 ctrl t1", 12'h010, 32'h0);
        rd_check("R1 reload t5", 12'h054, 32'h0);
        rd_check("R1 count t8", 12'h08C, 32'h0);
    endtask

    task automatic t_level_oneshot();
        apb_wr(12'h014, 32'd5);
        apb_wr(12'h010, 32'h26);
        rd_check("R4 count loaded", 12'h01C, 32'd5);
        ticks(4);
        rd_check("R5 count after 4 ticks", 12'h01C, 32'd1);
        rd_check("R5 no early expiry", 12'h000, 32'h0);
        ticks(1);
        check("R9 level irq high", 32'(irq[0]), 32'h1);
        rd_check("R8 status bit0", 12'h000, 32'h1);
        rd_check("R6 count zero", 12'h01C, 32'h0);
        rd_check("R6 start cleared", 12'h010, 32'h24);
        ticks(3);
        check("R9 level irq held", 32'(irq[0]), 32'h1);
    endtask

    task automatic t_pulse_auto();
        pulse_hits = 0;
        apb_wr(12'h024, 32'd3);
        apb_wr(12'h020, 32'h76);
        ticks(9);
        check("R10 one pulse per expiry", 32'(pulse_hits), 32'd3);
        rd_check("R7 reloaded count", 12'h02C, 32'd3);
        check("R10 pulse ended", 32'(irq[1]), 32'h0);
        rd_check("R8 status two bits", 12'h000, 32'h3);
        apb_wr(12'h020, 32'h0);
    endtask

    task automatic t_w1c();
        apb_wr(12'h000, 32'h2);
        rd_check("R11 only bit1 cleared", 12'h000, 32'h1);
        check("R11 irq0 untouched", 32'(irq[0]), 32'h1);
        apb_wr(12'h000, 32'h1);
        rd_check("R11 bit0 cleared", 12'h000, 32'h0);
        check("R9 irq0 dropped", 32'(irq[0]), 32'h0);
    endtask

    task automatic t_no_ien();
        apb_wr(12'h034, 32'd2);
        apb_wr(12'h030, 32'h06);
        ticks(2);
        rd_check("R8 no status", 12'h000, 32'h0);
        check("R8 no irq", 32'(irq), 32'h0);
        rd_check("R6 stopped t3", 12'h030, 32'h04);
    endtask

    task automatic t_stop_resume();
        apb_wr(12'h044, 32'd10);
        apb_wr(12'h040, 32'h06);
        ticks(3);
        rd_check("R5 count 7", 12'h04C, 32'd7);
        apb_wr(12'h040, 32'h00);
        rd_check("R13 stopped reads 0", 12'h04C, 32'd0);
        ticks(5);
        apb_wr(12'h040, 32'h02);
        rd_check("R13 resume value", 12'h04C, 32'd7);
        apb_wr(12'h04C, 32'h1234);
        rd_check("R3 count write ignored", 12'h04C, 32'd7);
        apb_wr(12'h040, 32'h00);
    endtask

    task automatic t_map();
        apb_wr(12'h088, 32'hCAFE_0001);
        rd_check("R2 compare t8", 12'h088, 32'hCAFE_0001);
        apb_wr(12'h080, 32'hFFFF_FF79);
        rd_check("R2 ctrl mask", 12'h080, 32'h71);
        apb_wr(12'h064, 32'h55);
        rd_check("R2 reload t6", 12'h064, 32'h55);
        rd_check("R2 reload t1 separate", 12'h014, 32'd5);
    endtask

    task automatic t_undefined();
        apb_wr(12'h090, 32'hFFFF_FFFF);
        apb_wr(12'h004, 32'hFFFF_FFFF);
        apb_wr(12'h0A4, 32'hFFFF_FFFF);
        apb_wr(12'h015, 32'hFFFF_FFFF);
        rd_check("R3 rev reads 0", 12'h090, 32'h0);
        rd_check("R3 bank0 hole", 12'h004, 32'h0);
        rd_check("R3 beyond last", 12'h0A4, 32'h0);
        rd_check("R3 unaligned read", 12'h015, 32'h0);
        rd_check("R3 reload t1 unchanged", 12'h014, 32'd5);
        rd_check("R3 status unchanged", 12'h000, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_level_oneshot();
        t_pulse_auto();
        t_w1c();
        t_no_ien();
        t_stop_resume();
        t_map();
        t_undefined();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule